// File: doc/BRIEF.md
# I2C Downstream Segment Selector

This block connects one I2C master port to as many as three downstream I2C segments, one segment at a time. A small host register in the master's 8-bit register space picks the segment whose SCL and SDA are joined to the master. Every other segment has both of its lines released, so its pull-ups hold it high.

The same register reports which segments are fitted on the board. That set is fixed when the block is built. If the host names a segment that is not fitted, or uses the spare code 3, no segment is connected. The master then sees an idle bus, apart from its own drive.

All lines use open-drain form. An `_oe` output of 1 pulls the line low, and an `_in` input is the level seen on the wire.

Top module: `i2c_seg_select`

## Requirements
- R1: After reset the selection field holds 0, which selects segment 0.
- R2: A write at byte offset 6 loads only write-data bits 1:0 into the selection field. Bits 7:2 of the write data are dropped.
- R3: A write at any other offset leaves the selection field unchanged.
- R4: A read at offset 6 returns the selection in bits 1:0 and the fitted-segment mask in bits 6:4 (bit 4+i set when segment i is fitted). Bits 7, 3 and 2 read 0.
- R5: When the selected segment is fitted, its SCL and SDA pull-down outputs follow the master's SCL and SDA drive.
- R6: Every segment that is not selected has both pull-down outputs at 0, whatever the master drives.
- R7: The master's SCL and SDA inputs read low when the master pulls that line low or the selected fitted segment's line is low.
- R8: When the selection names an unfitted segment or the code 3, all segment outputs are 0. The master inputs then read high unless the master itself pulls the line low.
- R9: A new selection takes effect from the clock edge that captures the write. Before that edge the old routing stays in force.
- R10: A read at any offset other than 6 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | AW | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| m_scl_oe | input | 1 | Master pulls SCL low |
| m_sda_oe | input | 1 | Master pulls SDA low |
| m_scl_in | output | 1 | SCL level seen by the master |
| m_sda_in | output | 1 | SDA level seen by the master |
| seg_scl_in | input | NSEG | SCL level of each segment |
| seg_sda_in | input | NSEG | SDA level of each segment |
| seg_scl_oe | output | NSEG | Pull SCL low on each segment |
| seg_sda_oe | output | NSEG | Pull SDA low on each segment |

## Verification
The bench builds the block with three segments and a fitted mask of 3'b101. Segment 1 is therefore missing, which makes the unfitted-segment case reachable next to the code-3 case. Each segment can be held low while it is not selected, so leakage between segments would be seen at the master inputs.

// File: rtl/i2c_seg_select.sv
module i2c_seg_select #(
  parameter int unsigned AW = 3,
  parameter int unsigned NSEG = 3,
  parameter logic [NSEG-1:0] PRESENT = '1,
  parameter int unsigned SEL_OFFSET = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_wr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            m_scl_oe,
  input  logic            m_sda_oe,
  output logic            m_scl_in,
  output logic            m_sda_in,
  input  logic [NSEG-1:0] seg_scl_in,
  input  logic [NSEG-1:0] seg_sda_in,
  output logic [NSEG-1:0] seg_scl_oe,
  output logic [NSEG-1:0] seg_sda_oe
);
  localparam int unsigned PAD = 4 - NSEG;
  localparam logic [3:0] FIT4 = 4'(PRESENT);

  logic [1:0] sel;
  logic       hit;
  logic       sel_ok;
  logic [3:0] scl4, sda4;
  logic       unused_wdata;

  assign hit = (reg_addr == AW'(SEL_OFFSET));
  assign unused_wdata = &{1'b0, reg_wdata[7:2]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sel <= 2'd0;
    else if (reg_wr && hit) sel <= reg_wdata[1:0];

  assign sel_ok = FIT4[sel];

  generate
    if (PAD > 0) begin : g_pad
      assign scl4 = {{PAD{1'b1}}, seg_scl_in};
      assign sda4 = {{PAD{1'b1}}, seg_sda_in};
    end else begin : g_nopad
      assign scl4 = seg_scl_in;
      assign sda4 = seg_sda_in;
    end
  endgenerate

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    assign seg_scl_oe[i] = sel_ok && (sel == 2'(i)) && m_scl_oe;
    assign seg_sda_oe[i] = sel_ok && (sel == 2'(i)) && m_sda_oe;
  end

  assign m_scl_in = !m_scl_oe && (!sel_ok || scl4[sel]);
  assign m_sda_in = !m_sda_oe && (!sel_ok || sda4[sel]);

  assign reg_rdata = hit ? {1'b0, FIT4[2:0], 2'b00, sel} : 8'h00;
endmodule

// File: rtl/i2c_seg_select_chk.sv
module i2c_seg_select_chk #(
  parameter int unsigned AW = 3,
  parameter int unsigned NSEG = 3,
  parameter logic [NSEG-1:0] PRESENT = '1,
  parameter int unsigned SEL_OFFSET = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   reg_addr,
  input logic            reg_wr,
  input logic [7:0]      reg_wdata,
  input logic [7:0]      reg_rdata,
  input logic            m_scl_oe,
  input logic            m_scl_in,
  input logic [NSEG-1:0] seg_scl_oe,
  input logic [NSEG-1:0] seg_sda_oe,
  input logic [1:0]      sel
);
  localparam logic [3:0] FIT4 = 4'(PRESENT);
  logic wr_sel;
  assign wr_sel = reg_wr && (reg_addr == AW'(SEL_OFFSET));

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> sel == $past(reg_wdata[1:0]));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(sel));
  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(SEL_OFFSET)) |-> reg_rdata[6:4] == 3'(PRESENT));
  p_one_scl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(seg_scl_oe));
  p_one_sda_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(seg_sda_oe));
  p_absent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !FIT4[sel] |-> (seg_scl_oe == '0) && (seg_sda_oe == '0));
  p_own_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_scl_oe |-> !m_scl_in);
endmodule

bind i2c_seg_select i2c_seg_select_chk #(
  .AW(AW), .NSEG(NSEG), .PRESENT(PRESENT), .SEL_OFFSET(SEL_OFFSET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .m_scl_oe(m_scl_oe),
  .m_scl_in(m_scl_in), .seg_scl_oe(seg_scl_oe), .seg_sda_oe(seg_sda_oe),
  .sel(sel)
);

// File: tb/i2c_seg_select_test.sv
module i2c_seg_select_test;
  localparam logic [2:0] FIT = 3'b101;
  logic clk = 0, rst_n = 0;
  logic [2:0] reg_addr = 3'd6;
  logic reg_wr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic m_scl_oe = 0, m_sda_oe = 0, m_scl_in, m_sda_in;
  logic [2:0] seg_scl_in = 3'b111, seg_sda_in = 3'b111, seg_scl_oe, seg_sda_oe;
  int checks = 0, fails = 0;
  logic [1:0] msel = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  i2c_seg_select #(.AW(3), .NSEG(3), .PRESENT(FIT), .SEL_OFFSET(6)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .m_scl_oe(m_scl_oe),
    .m_sda_oe(m_sda_oe), .m_scl_in(m_scl_in), .m_sda_in(m_sda_in),
    .seg_scl_in(seg_scl_in), .seg_sda_in(seg_sda_in),
    .seg_scl_oe(seg_scl_oe), .seg_sda_oe(seg_sda_oe));

  function automatic logic [15:0] model(logic [1:0] s, logic [2:0] a, logic mc, logic md,
                                        logic [2:0] sc, logic [2:0] sd);
    logic ok;
    logic [7:0] rd;
    logic [2:0] co, dd;
    logic mi_c, mi_d;
    ok = (s != 2'd3) && FIT[s];
    rd = (a == 3'd6) ? {1'b0, FIT, 2'b00, s} : 8'h00;
    co = 3'b000; dd = 3'b000;
    mi_c = !mc; mi_d = !md;
    if (ok) begin
      co[s] = mc; dd[s] = md;
      mi_c = mi_c && sc[s]; mi_d = mi_d && sd[s];
    end
    return {rd, mi_c, mi_d, co, dd};
  endfunction

  task automatic drive(logic [2:0] a, logic wr, logic [7:0] wd, logic mc, logic md,
                       logic [2:0] sc, logic [2:0] sd, string tag);
    @(posedge clk); #1;
    reg_addr = a; reg_wr = wr; reg_wdata = wd;
    m_scl_oe = mc; m_sda_oe = md; seg_scl_in = sc; seg_sda_in = sd;
    exp_q.push_back(model(msel, a, mc, md, sc, sd));
    tag_q.push_back(tag);
    if (wr && a == 3'd6) msel = wd[1:0];
  endtask

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      logic [15:0] e, got;
      string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      got = {reg_rdata, m_scl_in, m_sda_in, seg_scl_oe, seg_sda_oe};
      checks++;
      if (got !== e) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", t, got, e);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    drive(6, 0, 0, 0, 0, 3'b111, 3'b111, "R1 R4 reset readback");
    drive(6, 0, 0, 1, 0, 3'b111, 3'b111, "R5 R7 seg0 scl follow");
    drive(6, 0, 0, 0, 1, 3'b111, 3'b111, "R5 seg0 sda follow");
    drive(6, 0, 0, 0, 0, 3'b111, 3'b110, "R7 seg0 sda low seen");
    drive(6, 0, 0, 1, 1, 3'b011, 3'b011, "R6 seg2 low ignored");
    drive(6, 1, 8'hFE, 0, 0, 3'b111, 3'b111, "R9 old sel before edge");
    drive(6, 0, 0, 0, 0, 3'b111, 3'b111, "R2 R9 sel2 readback");
    drive(6, 0, 0, 1, 0, 3'b111, 3'b111, "R5 seg2 scl follow");
    drive(6, 0, 0, 0, 0, 3'b110, 3'b011, "R6 R7 seg2 routing");
    drive(5, 1, 8'h01, 0, 0, 3'b111, 3'b111, "R10 other offset read");
    drive(6, 0, 0, 0, 0, 3'b111, 3'b111, "R3 sel unchanged");
    drive(6, 1, 8'h01, 0, 0, 3'b111, 3'b111, "R9 write absent");
    drive(6, 0, 0, 1, 0, 3'b000, 3'b000, "R8 absent seg1 released");
    drive(6, 0, 0, 0, 1, 3'b000, 3'b000, "R8 absent own drive");
    drive(6, 1, 8'h03, 0, 0, 3'b111, 3'b111, "R9 write code3");
    drive(6, 0, 0, 1, 1, 3'b000, 3'b000, "R8 code3 released");
    drive(6, 0, 0, 0, 0, 3'b000, 3'b000, "R8 code3 idle high");
    drive(6, 1, 8'hFC, 0, 0, 3'b111, 3'b111, "R2 back to seg0");
    drive(6, 0, 0, 1, 1, 3'b101, 3'b101, "R5 R6 seg0 again");
    drive(3, 0, 0, 0, 0, 3'b111, 3'b111, "R10 offset3 zero");
    @(posedge clk); @(negedge clk); #1;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule